// File: doc/BRIEF.md
# Command Block Parser and Status Reporter

This block sits between the command phase of a disk controller's host port and the logic that carries out each command. It takes in a six-byte command block, one byte per accepted cycle, and splits it into command class, opcode, unit number, a 21-bit logical block address, a count or interleave byte and the two option bits of the control byte. It also decides whether the command is one the controller knows, and whether that command carries a logical address.

The block holds the error state for each command. An illegal command records the invalid-command code on its own. The execution logic can report a drive or controller error with a code, a type and the failing address. When the execution logic asks for them, the block sends out the two completion bytes that close every command, or the four sense bytes that a request-sense command returns. Each goes out as a burst of one byte per cycle.

Top module: `cmd_block_unit`

## Requirements
- R1: The first byte in a block splits into class (bits 7:5) and opcode (bits 4:0). The second byte gives the unit in bits 6:5 (`cmd_floppy` is bit 6) and the top five address bits in bits 4:0. The third and fourth bytes give the middle and low address bytes. The fifth byte is the count. In the sixth byte, bit 7 is `cmd_no_retry` and bit 6 is `cmd_no_reread`.
- R2: `cmd_valid` is high for exactly one cycle. That cycle is the one after the clock edge that accepts the sixth byte of a block.
- R3: These commands are accepted: class 0 opcodes 0x00, 0x01, 0x03–0x08, 0x0A and 0x0B; class 6 with any opcode; class 7 with any opcode. Any other command is invalid. An invalid command records error type 2 with code 0 (sense byte 0 reads 0x20, address-valid clear) and sets the completion error flag.
- R4: Class 0 opcodes 0x04–0x08, 0x0A and 0x0B carry an address, and so do all class 6 commands. After a command that is not request-sense, address-valid equals this property. For example, a recalibrate (0x01) leaves it clear.
- R5: Completion byte 0 is {0, unit[1:0], 000, err, 0}, where unit is the current command's unit and err is its error flag. Completion byte 1 is 0x00.
- R6: Sense byte 0 is {addr_valid, 0, type[1:0], code[3:0]}. Sense byte 1 is {0, unit[1:0], addr[20:16]}. Sense bytes 2 and 3 are addr[15:8] and addr[7:0]. The unit and address are those recorded from the last command that was not request-sense, or from a later error report.
- R7: A command that is not request-sense (class 0, opcode 0x03) clears the recorded type and code, unless the command is invalid. A request-sense command leaves the recorded error state unchanged.
- R8: An error report (`err_valid`) records its type, code and address and sets the current command's completion error flag.
- R9: Sending the last sense byte clears the recorded type and code. Address-valid and the recorded address are kept.
- R10: The bytes of a burst appear on consecutive cycles, starting the cycle after the request edge. `out_last` marks the final byte, and `out_valid` drops after it. A request made while a burst is in progress is ignored. If both requests arrive together, the completion burst wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Command byte present this cycle |
| in_byte | input | 8 | Command byte |
| cmd_valid | output | 1 | Decoded block is new (one-cycle pulse) |
| cmd_class | output | 3 | Command class |
| cmd_opcode | output | 5 | Opcode |
| cmd_unit | output | 2 | Unit number |
| cmd_floppy | output | 1 | Unit is a floppy drive |
| cmd_lba | output | 21 | Logical block address |
| cmd_count | output | 8 | Interleave or block count |
| cmd_no_retry | output | 1 | Automatic retries disabled |
| cmd_no_reread | output | 1 | Correct without re-read |
| cmd_ok | output | 1 | Command is valid |
| cmd_has_addr | output | 1 | Command carries a logical address |
| err_valid | input | 1 | Execution logic reports an error |
| err_code | input | 4 | Reported error code |
| err_type | input | 2 | Reported error type |
| err_lba | input | 21 | Failing logical address |
| status_req | input | 1 | Send the completion bytes |
| sense_req | input | 1 | Send the sense bytes |
| out_valid | output | 1 | Output byte present |
| out_byte | output | 8 | Output byte |
| out_last | output | 1 | Final byte of a burst |

## Verification
Some properties are checked on every cycle. The single-cycle `cmd_valid` pulse, the update of the recorded error state after each command (cleared, set to invalid-command, or held across request-sense), the handling of address-valid, the read-clear after the final sense byte, and the framing of each output burst are all checked this way. The exact bit layout of the completion and sense bytes for many commands can only be shown by the bench's scenarios. The same holds for how the valid opcodes and address-carrying commands are classified, for an error report followed by back-to-back sense reads, and for a request that arrives during a burst being ignored.

// File: rtl/cbu_pkg.sv
// Package: shared constants, the decoded command record and the opcode
// classification helpers for the command block unit.
// Assumes one command block is six bytes and addresses are 21 bits wide.
package cbu_pkg;

    localparam int BLK_BYTES  = 6;
    localparam int LBA_W      = 21;
    localparam int COMP_LEN   = 2;
    localparam int SENSE_LEN  = 4;

    localparam logic [2:0] CLS_STD  = 3'd0;
    localparam logic [2:0] CLS_COPY = 3'd6;
    localparam logic [2:0] CLS_DIAG = 3'd7;
    localparam logic [4:0] OPC_SENSE = 5'h03;

    localparam logic [1:0] TYPE_BADCMD = 2'd2;
    localparam logic [3:0] CODE_BADCMD = 4'h0;

    typedef struct packed {
        logic [2:0]       cls;
        logic [4:0]       opc;
        logic [1:0]       unit;
        logic [LBA_W-1:0] lba;
        logic [7:0]       count;
        logic [7:0]       ctrl;
    } cmd_t;

    typedef enum logic [1:0] {EM_IDLE, EM_COMP, EM_SENSE} emit_mode_t;

    // Class 0 opcodes the controller knows.
    function automatic logic std_op_known(input logic [4:0] opc);
        case (opc)
            5'h00, 5'h01, 5'h03, 5'h04, 5'h05, 5'h06,
            5'h07, 5'h08, 5'h0A, 5'h0B: return 1'b1;
            default:                   return 1'b0;
        endcase
    endfunction

    // Class 0 opcodes whose block carries a logical address.
    function automatic logic std_op_addr(input logic [4:0] opc);
        case (opc)
            5'h04, 5'h05, 5'h06, 5'h07,
            5'h08, 5'h0A, 5'h0B: return 1'b1;
            default:             return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/cbu_collect.sv
// Module: gathers the bytes of one command block into registers.
// Assumes bytes arrive in order, one per cycle with in_valid high, and that
// the next block does not start before the current one has been used.
module cbu_collect #(
    parameter int NBYTES = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [7:0]             in_byte,
    output logic [NBYTES-1:0][7:0] blk_bytes,
    output logic                   blk_done
);
    localparam int IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(NBYTES - 1);

    logic [IDX_W-1:0] pos;

    // Position counter and the end-of-block pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos      <= '0;
            blk_done <= 1'b0;
        end else begin
            blk_done <= in_valid && (pos == LAST_POS);
            if (in_valid)
                pos <= (pos == LAST_POS) ? '0 : pos + 1'b1;
        end
    end

    // One holding register per byte slot.
    for (genvar g = 0; g < NBYTES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                blk_bytes[g] <= 8'h00;
            else if (in_valid && pos == IDX_W'(g))
                blk_bytes[g] <= in_byte;
        end
    end

    // R2
    cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |=> !blk_done);

endmodule

// File: rtl/cbu_check.sv
// Module: classifies a decoded command as valid or not, as carrying an
// address or not, and as a request-sense or not. Purely combinational.
module cbu_check
    import cbu_pkg::*;
(
    input  cmd_t cmd,
    output logic ok,
    output logic has_addr,
    output logic is_sense
);
    // Decide validity and address presence from the class and opcode.
    always_comb begin
        case (cmd.cls)
            CLS_STD: begin
                ok       = std_op_known(cmd.opc);
                has_addr = std_op_addr(cmd.opc);
            end
            CLS_COPY: begin
                ok       = 1'b1;
                has_addr = 1'b1;
            end
            CLS_DIAG: begin
                ok       = 1'b1;
                has_addr = 1'b0;
            end
            default: begin
                ok       = 1'b0;
                has_addr = 1'b0;
            end
        endcase
        is_sense = ok && (cmd.cls == CLS_STD) && (cmd.opc == OPC_SENSE);
    end

endmodule

// File: rtl/cbu_errstate.sv
// Module: holds the per-command error state: the current command's unit and
// error flag, and the recorded type, code, address-valid, unit and address
// reported by the sense bytes.
// Assumes a new command takes priority over an error report in the same cycle.
module cbu_errstate
    import cbu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_ok,
    input  logic             cmd_addr,
    input  logic             cmd_sense,
    input  logic [1:0]       cmd_unit,
    input  logic [LBA_W-1:0] cmd_lba,
    input  logic             err_valid,
    input  logic [3:0]       err_code,
    input  logic [1:0]       err_type,
    input  logic [LBA_W-1:0] err_lba,
    input  logic             sense_done,
    output logic [1:0]       cur_unit,
    output logic             cur_err,
    output logic [3:0]       rec_code,
    output logic [1:0]       rec_type,
    output logic             rec_addr_valid,
    output logic [1:0]       rec_unit,
    output logic [LBA_W-1:0] rec_lba
);
    // Update the error state on new commands, error reports and sense reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_unit       <= 2'd0;
            cur_err        <= 1'b0;
            rec_code       <= 4'h0;
            rec_type       <= 2'd0;
            rec_addr_valid <= 1'b0;
            rec_unit       <= 2'd0;
            rec_lba        <= '0;
        end else if (cmd_valid) begin
            cur_unit <= cmd_unit;
            cur_err  <= !cmd_ok;
            if (!cmd_sense) begin
                rec_unit       <= cmd_unit;
                rec_lba        <= cmd_lba;
                rec_addr_valid <= cmd_ok && cmd_addr;
                if (cmd_ok) begin
                    rec_type <= 2'd0;
                    rec_code <= 4'h0;
                end else begin
                    rec_type <= TYPE_BADCMD;
                    rec_code <= CODE_BADCMD;
                end
            end
        end else if (err_valid) begin
            cur_err  <= 1'b1;
            rec_type <= err_type;
            rec_code <= err_code;
            rec_lba  <= err_lba;
        end else if (sense_done) begin
            rec_type <= 2'd0;
            rec_code <= 4'h0;
        end
    end

    // R7
    clear_on_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ok && !cmd_sense) |=> (rec_code == 4'h0 && rec_type == 2'd0));

    // R7
    sense_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_sense) |=> ($stable(rec_code) && $stable(rec_type) && $stable(rec_addr_valid)));

    // R3
    bad_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ok) |=> ({rec_type, rec_code} == 6'h20 && cur_err && !rec_addr_valid));

    // R4
    addr_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ok && !cmd_sense) |=> (rec_addr_valid == $past(cmd_addr)));

    // R9
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_done && !cmd_valid && !err_valid) |=> (rec_code == 4'h0 && $stable(rec_addr_valid)));

    // R8
    err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && !cmd_valid) |=> cur_err);

endmodule

// File: rtl/cbu_emit.sv
// Module: sends the completion bytes or the sense bytes as a burst of one
// byte per cycle on request. Requests made during a burst are ignored, and
// a completion request wins over a sense request in the same cycle.
module cbu_emit
    import cbu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             status_req,
    input  logic             sense_req,
    input  logic [1:0]       cur_unit,
    input  logic             cur_err,
    input  logic [3:0]       rec_code,
    input  logic [1:0]       rec_type,
    input  logic             rec_addr_valid,
    input  logic [1:0]       rec_unit,
    input  logic [LBA_W-1:0] rec_lba,
    output logic             out_valid,
    output logic [7:0]       out_byte,
    output logic             out_last,
    output logic             sense_done
);
    localparam int IDX_W = $clog2(SENSE_LEN);
    localparam logic [IDX_W-1:0] COMP_END  = IDX_W'(COMP_LEN - 1);
    localparam logic [IDX_W-1:0] SENSE_END = IDX_W'(SENSE_LEN - 1);

    emit_mode_t       mode;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] end_idx;

    // Index of the final byte in the running burst.
    always_comb end_idx = (mode == EM_COMP) ? COMP_END : SENSE_END;

    // Burst sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= EM_IDLE;
            idx  <= '0;
        end else if (mode == EM_IDLE) begin
            idx <= '0;
            if (status_req)
                mode <= EM_COMP;
            else if (sense_req)
                mode <= EM_SENSE;
        end else if (idx == end_idx) begin
            mode <= EM_IDLE;
            idx  <= '0;
        end else begin
            idx <= idx + 1'b1;
        end
    end

    // Output byte selection for the current burst position.
    always_comb begin
        out_valid  = (mode != EM_IDLE);
        out_last   = out_valid && (idx == end_idx);
        sense_done = (mode == EM_SENSE) && (idx == SENSE_END);
        out_byte   = 8'h00;
        if (mode == EM_COMP) begin
            if (idx == '0)
                out_byte = {1'b0, cur_unit, 3'b000, cur_err, 1'b0};
        end else if (mode == EM_SENSE) begin
            case (idx)
                IDX_W'(0): out_byte = {rec_addr_valid, 1'b0, rec_type, rec_code};
                IDX_W'(1): out_byte = {1'b0, rec_unit, rec_lba[LBA_W-1 -: 5]};
                IDX_W'(2): out_byte = rec_lba[15:8];
                default:   out_byte = rec_lba[7:0];
            endcase
        end
    end

    // R10
    burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |=> !out_valid);

    // R10
    burst_gapless_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> out_valid);

    // R10
    burst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(status_req || sense_req));

    // R5
    comp_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last && mode == EM_COMP) |=> (out_byte == 8'h00));

endmodule

// File: rtl/cmd_block_unit.sv
// Module: top of the command block unit. It collects the six-byte command
// block, decodes and classifies it, keeps the error state and sends the
// completion and sense bytes. Command execution lives outside this block.
module cmd_block_unit
    import cbu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             cmd_valid,
    output logic [2:0]       cmd_class,
    output logic [4:0]       cmd_opcode,
    output logic [1:0]       cmd_unit,
    output logic             cmd_floppy,
    output logic [20:0]      cmd_lba,
    output logic [7:0]       cmd_count,
    output logic             cmd_no_retry,
    output logic             cmd_no_reread,
    output logic             cmd_ok,
    output logic             cmd_has_addr,
    input  logic             err_valid,
    input  logic [3:0]       err_code,
    input  logic [1:0]       err_type,
    input  logic [20:0]      err_lba,
    input  logic             status_req,
    input  logic             sense_req,
    output logic             out_valid,
    output logic [7:0]       out_byte,
    output logic             out_last
);
    logic [BLK_BYTES-1:0][7:0] blk;
    cmd_t                      cmd;
    logic                      is_sense;
    logic                      sense_done;
    logic [1:0]                cur_unit;
    logic                      cur_err;
    logic [3:0]                rec_code;
    logic [1:0]                rec_type;
    logic                      rec_addr_valid;
    logic [1:0]                rec_unit;
    logic [LBA_W-1:0]          rec_lba;

    cbu_collect #(.NBYTES(BLK_BYTES)) u_collect (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .blk_bytes (blk),
        .blk_done  (cmd_valid)
    );

    // Split the collected bytes into command fields.
    always_comb begin
        cmd.cls   = blk[0][7:5];
        cmd.opc   = blk[0][4:0];
        cmd.unit  = blk[1][6:5];
        cmd.lba   = {blk[1][4:0], blk[2], blk[3]};
        cmd.count = blk[4];
        cmd.ctrl  = blk[5];
    end

    cbu_check u_check (
        .cmd      (cmd),
        .ok       (cmd_ok),
        .has_addr (cmd_has_addr),
        .is_sense (is_sense)
    );

    cbu_errstate u_err (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_valid      (cmd_valid),
        .cmd_ok         (cmd_ok),
        .cmd_addr       (cmd_has_addr),
        .cmd_sense      (is_sense),
        .cmd_unit       (cmd.unit),
        .cmd_lba        (cmd.lba),
        .err_valid      (err_valid),
        .err_code       (err_code),
        .err_type       (err_type),
        .err_lba        (err_lba),
        .sense_done     (sense_done),
        .cur_unit       (cur_unit),
        .cur_err        (cur_err),
        .rec_code       (rec_code),
        .rec_type       (rec_type),
        .rec_addr_valid (rec_addr_valid),
        .rec_unit       (rec_unit),
        .rec_lba        (rec_lba)
    );

    cbu_emit u_emit (
        .clk            (clk),
        .rst_n          (rst_n),
        .status_req     (status_req),
        .sense_req      (sense_req),
        .cur_unit       (cur_unit),
        .cur_err        (cur_err),
        .rec_code       (rec_code),
        .rec_type       (rec_type),
        .rec_addr_valid (rec_addr_valid),
        .rec_unit       (rec_unit),
        .rec_lba        (rec_lba),
        .out_valid      (out_valid),
        .out_byte       (out_byte),
        .out_last       (out_last),
        .sense_done     (sense_done)
    );

    // Drive the decoded command outputs.
    always_comb begin
        cmd_class     = cmd.cls;
        cmd_opcode    = cmd.opc;
        cmd_unit      = cmd.unit;
        cmd_floppy    = cmd.unit[1];
        cmd_lba       = cmd.lba;
        cmd_count     = cmd.count;
        cmd_no_retry  = cmd.ctrl[7];
        cmd_no_reread = cmd.ctrl[6];
    end

endmodule

// File: tb/tb_cmd_block_unit.sv
`timescale 1ns/1ps
module tb_cmd_block_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [7:0]  in_byte;
    logic        cmd_valid;
    logic [2:0]  cmd_class;
    logic [4:0]  cmd_opcode;
    logic [1:0]  cmd_unit;
    logic        cmd_floppy;
    logic [20:0] cmd_lba;
    logic [7:0]  cmd_count;
    logic        cmd_no_retry;
    logic        cmd_no_reread;
    logic        cmd_ok;
    logic        cmd_has_addr;
    logic        err_valid;
    logic [3:0]  err_code;
    logic [1:0]  err_type;
    logic [20:0] err_lba;
    logic        status_req;
    logic        sense_req;
    logic        out_valid;
    logic [7:0]  out_byte;
    logic        out_last;

    int total = 0;
    int bad   = 0;
    logic [7:0] rd [0:3];

    always #2 clk = ~clk;

    cmd_block_unit dut (.*);

    // Vector: {six command bytes, expected valid, expected address-carrying}
    localparam int NVEC = 11;
    localparam logic [49:0] VEC [NVEC] = '{
        {8'h08, 8'h2A, 8'h34, 8'h56, 8'h01, 8'h00, 1'b1, 1'b1},  // read, unit 1
        {8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0},  // recalibrate
        {8'h00, 8'h60, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0},  // test ready, floppy 1
        {8'h02, 8'h20, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0},  // reserved 0x02
        {8'h0C, 8'h00, 8'h11, 8'h22, 8'h00, 8'h00, 1'b0, 1'b0},  // reserved 0x0C
        {8'h21, 8'h00, 8'h00, 8'h05, 8'h00, 8'h00, 1'b0, 1'b0},  // class 1
        {8'hC0, 8'h5F, 8'hFF, 8'hFF, 8'h02, 8'h00, 1'b1, 1'b1},  // class 6 copy
        {8'hE3, 8'h20, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0},  // class 7 diag
        {8'h0A, 8'h40, 8'h00, 8'h01, 8'h11, 8'hC0, 1'b1, 1'b1},  // write, options set
        {8'hA3, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0},  // class 5
        {8'h04, 8'h33, 8'h00, 8'h10, 8'h03, 8'h80, 1'b1, 1'b1}   // format
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Send one block; returns at the negedge where cmd_valid is high.
    task automatic send_blk(input logic [47:0] blk);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_byte  = blk[47 - 8*i -: 8];
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Request a burst and capture n bytes, checking framing (R10).
    task automatic read_out(input bit sense, input int n);
        @(negedge clk);
        if (sense) sense_req = 1'b1; else status_req = 1'b1;
        @(negedge clk);
        sense_req  = 1'b0;
        status_req = 1'b0;
        for (int k = 0; k < n; k++) begin
            check("R10 out_valid", out_valid, 1);
            check("R10 out_last", out_last, (k == n - 1));
            rd[k] = out_byte;
            @(negedge clk);
        end
        check("R10 burst end", out_valid, 0);
    endtask

    task automatic do_sense();
        send_blk({8'h03, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00});
        @(negedge clk);
        read_out(1'b1, 4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_byte = 8'h00;
        err_valid = 1'b0; err_code = 4'h0; err_type = 2'd0; err_lba = '0;
        status_req = 1'b0; sense_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R2, R10)
        check("R2 reset cmd_valid", cmd_valid, 0);
        check("R10 reset out_valid", out_valid, 0);

        // Table walk: R1, R3, R4, R5, R6
        for (int v = 0; v < NVEC; v++) begin
            logic [47:0] b;
            logic        eok, ead;
            logic [1:0]  u;
            logic [20:0] a;
            b   = VEC[v][49:2];
            eok = VEC[v][1];
            ead = VEC[v][0];
            u   = b[38:37];
            a   = {b[36:32], b[31:24], b[23:16]};
            send_blk(b);
            check("R2 cmd_valid", cmd_valid, 1);
            check("R1 class", cmd_class, b[47:45]);
            check("R1 opcode", cmd_opcode, b[44:40]);
            check("R1 unit", cmd_unit, u);
            check("R1 floppy", cmd_floppy, u[1]);
            check("R1 lba", cmd_lba, a);
            check("R1 count", cmd_count, b[15:8]);
            check("R1 no_retry", cmd_no_retry, b[7]);
            check("R1 no_reread", cmd_no_reread, b[6]);
            check("R3 ok", cmd_ok, eok);
            check("R4 has_addr", cmd_has_addr, ead);
            @(negedge clk);
            check("R2 pulse width", cmd_valid, 0);
            read_out(1'b0, 2);
            check("R5 comp byte0", rd[0], {1'b0, u, 3'b000, !eok, 1'b0});
            check("R5 comp byte1", rd[1], 8'h00);
            do_sense();
            check("R6 R3 R4 sense byte0", rd[0], {ead, 1'b0, (eok ? 6'h00 : 6'h20)});
            check("R6 sense byte1", rd[1], {1'b0, u, a[20:16]});
            check("R6 sense byte2", rd[2], a[15:8]);
            check("R6 sense byte3", rd[3], a[7:0]);
        end

        // R5: completion of a request-sense carries its own unit, no error
        send_blk({8'h03, 8'h40, 8'h00, 8'h00, 8'h00, 8'h00});
        @(negedge clk);
        read_out(1'b0, 2);
        check("R5 sense cmd completion", rd[0], 8'h40);

        // R8: error report after a read
        send_blk({8'h08, 8'h01, 8'h02, 8'h03, 8'h01, 8'h00});
        @(negedge clk);
        err_valid = 1'b1; err_code = 4'h4; err_type = 2'd1; err_lba = 21'h012345;
        @(negedge clk);
        err_valid = 1'b0;
        read_out(1'b0, 2);
        check("R8 comp error flag", rd[0], 8'h02);
        do_sense();
        check("R8 sense byte0", rd[0], 8'h94);
        check("R8 sense byte1", rd[1], 8'h01);
        check("R8 sense byte2", rd[2], 8'h23);
        check("R8 sense byte3", rd[3], 8'h45);
        // R9: read clears code, keeps address-valid and address
        do_sense();
        check("R9 second sense byte0", rd[0], 8'h80);
        check("R9 second sense byte3", rd[3], 8'h45);

        // R7: error recorded, then recalibrate clears it and address-valid
        send_blk({8'h08, 8'h00, 8'h00, 8'h07, 8'h01, 8'h00});
        @(negedge clk);
        err_valid = 1'b1; err_code = 4'h2; err_type = 2'd0; err_lba = 21'h7;
        @(negedge clk);
        err_valid = 1'b0;
        send_blk({8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00});
        @(negedge clk);
        do_sense();
        check("R7 R4 cleared by recalibrate", rd[0], 8'h00);

        // R10: sense request during a completion burst is ignored
        @(negedge clk);
        status_req = 1'b1;
        @(negedge clk);
        status_req = 1'b0;
        sense_req  = 1'b1;
        check("R10 busy byte0", out_valid, 1);
        @(negedge clk);
        sense_req = 1'b0;
        check("R10 busy last", out_last, 1);
        @(negedge clk);
        check("R10 request ignored", out_valid, 0);

        // R10: both requests together, completion wins
        @(negedge clk);
        status_req = 1'b1; sense_req = 1'b1;
        @(negedge clk);
        status_req = 1'b0; sense_req = 1'b0;
        @(negedge clk);
        check("R10 priority last", out_last, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule